// File: doc/BRIEF.md
# Translation Mode Selector and Fault Classifier

This block sits at the entry of a memory-management unit. For every access it picks one of four paths for the virtual address: untranslated pass-through in direct-address mode, a hit in one of a set of privilege-filtered direct-map windows, rejection because the upper address bits are not a sign extension, or lookup in the TLB. When the TLB path is taken, the TLB's result code (supplied on the same cycle by the external TLB) becomes either a translation or an exception code. Refill faults are flagged separately so the core can vector to its refill handler.

All results are registered and appear one clock after the request. On any fault the offending virtual address is latched and held until the next fault. A no-match result also yields the virtual page-pair number (address bits VA_W-1 down to 13) for the refill handler.

Top module: `xlat_front`

## Requirements
- R1: When `direct_en`=1 and `paging_en`=0, the result has `out_path`=0, `out_paddr` = low PA_W bits of the address, `out_perm`=3'b111 (bit0 read, bit1 write, bit2 execute) and no fault, whatever the windows or TLB say.
- R2: Window w (bits [w*XLEN +: XLEN] of `win_cfg`) is eligible only when the privilege mask has a bit in common with its bits [3:0]. The mask is 4'b0001 for privilege level 0, 4'b1000 for level 3 and 4'b0000 for levels 1 and 2, so levels 1 and 2 never hit a window.
- R3: An eligible window hits when its bits [XLEN-1:VA_W] equal the address bits [XLEN-1:VA_W]. The lowest-numbered hit wins. The result has `out_path`=1, `out_win` = that index, `out_paddr` = low PA_W address bits, `out_perm`=3'b111 and no fault.
- R4: With no direct mode and no window hit, an address whose 16 bits [VA_W+15:VA_W] are neither all zeros nor all ones takes `out_path`=2 and faults. Otherwise it takes `out_path`=3 (TLB).
- R5: A path-2 fault, and TLB code 1, give exception 8 for a fetch (`req_acc`=2) and exception 9 for a load (0) or store (1).
- R6: On path 3 with TLB code 0, `out_paddr`=`tlb_paddr`, `out_perm`=`tlb_perm` and there is no fault.
- R7: TLB codes 2 (no match) and 3 (invalid) give exception 1 for a load, 2 for a store and 3 for a fetch. Only code 2 sets `out_refill`, with `out_vppn` = address bits [VA_W-1:13]. Otherwise `out_vppn`=0.
- R8: TLB code 4 (store to clean page) gives exception 4, code 5 (read inhibited) gives 5, code 6 (execute inhibited) gives 6 and code 7 (privilege violation) gives 7.
- R9: A faulting result has `out_perm`=0 and `out_paddr`=0. `out_badv` takes the request address on every fault and holds its value otherwise. Non-fault results have `out_exc`=0.
- R10: After synchronous reset all outputs are zero. A result appears one cycle after `req_valid`. A cycle without `req_valid` gives `out_valid`=0 with no fault and no refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_vaddr | input | XLEN | Virtual address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_plv | input | 2 | Privilege level |
| direct_en | input | 1 | Direct-address mode bit |
| paging_en | input | 1 | Paging mode bit |
| win_cfg | input | NWIN*XLEN | Window registers, window 0 in the low bits |
| tlb_code | input | 3 | TLB result code for this request |
| tlb_paddr | input | PA_W | TLB physical address |
| tlb_perm | input | 3 | TLB permissions |
| out_valid | output | 1 | Result valid |
| out_paddr | output | PA_W | Physical address |
| out_perm | output | 3 | Permissions (read, write, execute) |
| out_path | output | 2 | 0 direct, 1 window, 2 bad address, 3 TLB |
| out_win | output | WIN_IDX_W | Index of the hit window |
| out_fault | output | 1 | Fault |
| out_exc | output | 6 | Exception code |
| out_refill | output | 1 | Refill fault |
| out_vppn | output | VA_W-13 | Page-pair number for refill |
| out_badv | output | XLEN | Address of the last fault |

## Verification
Directed accesses first isolate each path. Direct mode is tried with windows that would otherwise hit. The privilege filter is tried at all four levels against windows enabled for only one level. Two overlapping windows check that the lower index wins. Fetch, load and store are each crossed with every TLB code, which separates the refill case from the invalid case and the four permission faults. A long run follows with random addresses whose upper bits are drawn mostly from the window tags and the canonical values, random mode bits and random idle cycles. Its purpose is to mix path choice, priority and fault-address retention in ways no directed case reaches.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // access types
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // translation paths
  localparam logic [1:0] PATH_DIRECT = 2'd0;
  localparam logic [1:0] PATH_WIN    = 2'd1;
  localparam logic [1:0] PATH_BAD    = 2'd2;
  localparam logic [1:0] PATH_TLB    = 2'd3;

  // TLB result codes
  localparam logic [2:0] TC_OK      = 3'd0;
  localparam logic [2:0] TC_ADDR    = 3'd1;
  localparam logic [2:0] TC_MISS    = 3'd2;
  localparam logic [2:0] TC_INVAL   = 3'd3;
  localparam logic [2:0] TC_CLEAN   = 3'd4;
  localparam logic [2:0] TC_NOREAD  = 3'd5;
  localparam logic [2:0] TC_NOEXEC  = 3'd6;
  localparam logic [2:0] TC_PRIV    = 3'd7;

  // exception codes
  localparam int EXC_W = 6;
  localparam logic [EXC_W-1:0] EX_NONE      = 6'd0;
  localparam logic [EXC_W-1:0] EX_PG_LOAD   = 6'd1;
  localparam logic [EXC_W-1:0] EX_PG_STORE  = 6'd2;
  localparam logic [EXC_W-1:0] EX_PG_FETCH  = 6'd3;
  localparam logic [EXC_W-1:0] EX_PG_MODIFY = 6'd4;
  localparam logic [EXC_W-1:0] EX_PG_NORD   = 6'd5;
  localparam logic [EXC_W-1:0] EX_PG_NOEX   = 6'd6;
  localparam logic [EXC_W-1:0] EX_PG_PRIV   = 6'd7;
  localparam logic [EXC_W-1:0] EX_ADR_FETCH = 6'd8;
  localparam logic [EXC_W-1:0] EX_ADR_MEM   = 6'd9;
endpackage

// File: rtl/xlat_win_match.sv
module xlat_win_match #(
  parameter int XLEN  = 64,
  parameter int VA_W  = 48,
  parameter int NWIN  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NWIN*XLEN-1:0] win_cfg,
  input  logic [XLEN-VA_W-1:0] va_tag,
  input  logic [3:0]           plv_mask,
  output logic                 hit,
  output logic [IDX_W-1:0]     hit_idx
);
  localparam int TAG_W = XLEN - VA_W;

  logic [NWIN-1:0] raw;
  logic [NWIN*(VA_W-4)-1:0] cfg_mid;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [XLEN-1:0] cfg;
    assign cfg = win_cfg[w*XLEN +: XLEN];
    assign raw[w] = (|(cfg[3:0] & plv_mask)) && (cfg[XLEN-1 -: TAG_W] == va_tag);
    assign cfg_mid[w*(VA_W-4) +: (VA_W-4)] = cfg[VA_W-1:4];
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_mid;

  // lowest index wins: scan from the top so the last assignment is the lowest hit
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (raw[w]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(w);
      end
    end
  end
endmodule

// File: rtl/xlat_fault_map.sv
module xlat_fault_map
  import xlat_pkg::*;
(
  input  logic             active,
  input  logic             addr_bad,
  input  logic [1:0]       acc,
  input  logic [2:0]       code,
  output logic             fault,
  output logic [EXC_W-1:0] exc,
  output logic             refill
);
  logic [EXC_W-1:0] pg_exc;
  logic [EXC_W-1:0] adr_exc;

  always_comb begin
    unique case (acc)
      ACC_STORE: pg_exc = EX_PG_STORE;
      ACC_FETCH: pg_exc = EX_PG_FETCH;
      default:   pg_exc = EX_PG_LOAD;
    endcase
    adr_exc = (acc == ACC_FETCH) ? EX_ADR_FETCH : EX_ADR_MEM;
  end

  always_comb begin
    fault  = 1'b0;
    exc    = EX_NONE;
    refill = 1'b0;
    if (active) begin
      if (addr_bad) begin
        fault = 1'b1;
        exc   = adr_exc;
      end else begin
        fault = (code != TC_OK);
        unique case (code)
          TC_OK:     exc = EX_NONE;
          TC_MISS:   begin exc = pg_exc; refill = 1'b1; end
          TC_INVAL:  exc = pg_exc;
          TC_CLEAN:  exc = EX_PG_MODIFY;
          TC_NOREAD: exc = EX_PG_NORD;
          TC_NOEXEC: exc = EX_PG_NOEX;
          TC_PRIV:   exc = EX_PG_PRIV;
          default:   exc = adr_exc;
        endcase
      end
    end
  end
endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xlat_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int NWIN     = 4,
  parameter int EXT_W    = 16,
  parameter int VPPN_LSB = 13,
  localparam int WIN_IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int VPPN_W    = VA_W - VPPN_LSB
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [XLEN-1:0]        req_vaddr,
  input  logic [1:0]             req_acc,
  input  logic [1:0]             req_plv,
  input  logic                   direct_en,
  input  logic                   paging_en,
  input  logic [NWIN*XLEN-1:0]   win_cfg,
  input  logic [2:0]             tlb_code,
  input  logic [PA_W-1:0]        tlb_paddr,
  input  logic [2:0]             tlb_perm,
  output logic                   out_valid,
  output logic [PA_W-1:0]        out_paddr,
  output logic [2:0]             out_perm,
  output logic [1:0]             out_path,
  output logic [WIN_IDX_W-1:0]   out_win,
  output logic                   out_fault,
  output logic [EXC_W-1:0]       out_exc,
  output logic                   out_refill,
  output logic [VPPN_W-1:0]      out_vppn,
  output logic [XLEN-1:0]        out_badv
);
  localparam int TAG_W = XLEN - VA_W;

  logic [3:0]           plv_mask;
  logic                 win_hit;
  logic [WIN_IDX_W-1:0] win_idx;
  logic [EXT_W-1:0]     ext_bits;
  logic                 canon;
  logic                 bypass;

  assign plv_mask = {req_plv == 2'd3, 2'b00, req_plv == 2'd0};
  assign ext_bits = req_vaddr[VA_W +: EXT_W];
  assign canon    = (&ext_bits) | ~(|ext_bits);
  assign bypass   = direct_en & ~paging_en;

  xlat_win_match #(
    .XLEN(XLEN), .VA_W(VA_W), .NWIN(NWIN), .IDX_W(WIN_IDX_W)
  ) u_win (
    .win_cfg (win_cfg),
    .va_tag  (req_vaddr[XLEN-1 -: TAG_W]),
    .plv_mask(plv_mask),
    .hit     (win_hit),
    .hit_idx (win_idx)
  );

  logic [1:0]      path_n;
  logic [PA_W-1:0] paddr_n;
  logic [2:0]      perm_n;

  always_comb begin
    path_n  = PATH_TLB;
    paddr_n = '0;
    perm_n  = 3'b000;
    if (bypass) begin
      path_n  = PATH_DIRECT;
      paddr_n = req_vaddr[PA_W-1:0];
      perm_n  = 3'b111;
    end else if (win_hit) begin
      path_n  = PATH_WIN;
      paddr_n = req_vaddr[PA_W-1:0];
      perm_n  = 3'b111;
    end else if (!canon) begin
      path_n  = PATH_BAD;
    end else if (tlb_code == TC_OK) begin
      paddr_n = tlb_paddr;
      perm_n  = tlb_perm;
    end
  end

  logic             flt_n;
  logic [EXC_W-1:0] exc_n;
  logic             refill_n;

  xlat_fault_map u_fault (
    .active  (path_n == PATH_BAD || path_n == PATH_TLB),
    .addr_bad(path_n == PATH_BAD),
    .acc     (req_acc),
    .code    (tlb_code),
    .fault   (flt_n),
    .exc     (exc_n),
    .refill  (refill_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_paddr  <= '0;
      out_perm   <= '0;
      out_path   <= '0;
      out_win    <= '0;
      out_fault  <= 1'b0;
      out_exc    <= '0;
      out_refill <= 1'b0;
      out_vppn   <= '0;
      out_badv   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_paddr  <= paddr_n;
        out_perm   <= perm_n;
        out_path   <= path_n;
        out_win    <= (path_n == PATH_WIN) ? win_idx : '0;
        out_fault  <= flt_n;
        out_exc    <= exc_n;
        out_refill <= refill_n;
        out_vppn   <= refill_n ? req_vaddr[VA_W-1:VPPN_LSB] : '0;
        if (flt_n) out_badv <= req_vaddr;
      end else begin
        out_fault  <= 1'b0;
        out_refill <= 1'b0;
      end
    end
  end

  AST_DIRECT_FULL_PERM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_path == PATH_DIRECT) |-> (out_perm == 3'b111 && !out_fault)); // R1
  AST_WIN_FULL_PERM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_path == PATH_WIN) |-> (out_perm == 3'b111 && !out_fault)); // R3
  AST_BAD_ADDR_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_path == PATH_BAD) |-> (out_fault && (out_exc == EX_ADR_FETCH || out_exc == EX_ADR_MEM))); // R5
  AST_REFILL_IS_PAGE_FAULT: assert property (@(posedge clk) disable iff (rst)
    out_refill |-> (out_fault && out_path == PATH_TLB && out_exc >= EX_PG_LOAD && out_exc <= EX_PG_FETCH)); // R7
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (out_perm == 3'b000 && out_paddr == '0)); // R9
  AST_BADV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_fault |-> $stable(out_badv)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_fault && !out_refill)); // R10
endmodule

// File: tb/tb_xlat_front.sv
module tb_xlat_front;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [63:0]  req_vaddr;
  logic [1:0]   req_acc, req_plv;
  logic         direct_en, paging_en;
  logic [255:0] win_cfg;
  logic [2:0]   tlb_code;
  logic [47:0]  tlb_paddr;
  logic [2:0]   tlb_perm;
  logic         out_valid, out_fault, out_refill;
  logic [47:0]  out_paddr;
  logic [2:0]   out_perm;
  logic [1:0]   out_path, out_win;
  logic [5:0]   out_exc;
  logic [34:0]  out_vppn;
  logic [63:0]  out_badv;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_badv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_front dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_plv(req_plv), .direct_en(direct_en), .paging_en(paging_en),
    .win_cfg(win_cfg), .tlb_code(tlb_code), .tlb_paddr(tlb_paddr), .tlb_perm(tlb_perm),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_perm(out_perm), .out_path(out_path),
    .out_win(out_win), .out_fault(out_fault), .out_exc(out_exc), .out_refill(out_refill),
    .out_vppn(out_vppn), .out_badv(out_badv)
  );

  typedef struct packed {
    logic [1:0]  path;
    logic [1:0]  win;
    logic [47:0] paddr;
    logic [2:0]  perm;
    logic        fault;
    logic [5:0]  exc;
    logic        refill;
    logic [34:0] vppn;
  } exp_t;

  function automatic exp_t model(input logic [63:0] va, input logic [1:0] acc, plv,
                                 input logic den, pen, input logic [255:0] cfg,
                                 input logic [2:0] code, input logic [47:0] tpa,
                                 input logic [2:0] tperm);
    exp_t e = '0;
    logic [3:0] m;
    logic [5:0] pg;
    m  = {plv == 2'd3, 2'b00, plv == 2'd0};
    pg = (acc == 2'd1) ? 6'd2 : (acc == 2'd2) ? 6'd3 : 6'd1;
    if (den && !pen) begin
      e.path = 2'd0; e.paddr = va[47:0]; e.perm = 3'b111; return e;
    end
    for (int w = 0; w < 4; w++) begin
      logic [63:0] c;
      c = cfg[w*64 +: 64];
      if ((c[3:0] & m) != 4'd0 && c[63:48] == va[63:48]) begin
        e.path = 2'd1; e.win = 2'(w); e.paddr = va[47:0]; e.perm = 3'b111; return e;
      end
    end
    if (!(va[63:48] == 16'h0000 || va[63:48] == 16'hFFFF)) begin
      e.path = 2'd2; e.fault = 1'b1; e.exc = (acc == 2'd2) ? 6'd8 : 6'd9; return e;
    end
    e.path = 2'd3;
    case (code)
      3'd0: begin e.paddr = tpa; e.perm = tperm; end
      3'd1: begin e.fault = 1'b1; e.exc = (acc == 2'd2) ? 6'd8 : 6'd9; end
      3'd2: begin e.fault = 1'b1; e.exc = pg; e.refill = 1'b1; e.vppn = va[47:13]; end
      3'd3: begin e.fault = 1'b1; e.exc = pg; end
      3'd4: begin e.fault = 1'b1; e.exc = 6'd4; end
      3'd5: begin e.fault = 1'b1; e.exc = 6'd5; end
      3'd6: begin e.fault = 1'b1; e.exc = 6'd6; end
      default: begin e.fault = 1'b1; e.exc = 6'd7; end
    endcase
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic txn(input logic [63:0] va, input logic [1:0] acc, plv, input logic den, pen,
                     input logic [255:0] cfg, input logic [2:0] code, input logic [47:0] tpa,
                     input logic [2:0] tperm, input string ptag);
    exp_t e;
    string t;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_plv = plv;
    direct_en = den; paging_en = pen; win_cfg = cfg;
    tlb_code = code; tlb_paddr = tpa; tlb_perm = tperm;
    @(posedge clk); #1;
    e = model(va, acc, plv, den, pen, cfg, code, tpa, tperm);
    if (e.fault) exp_badv = va;
    case (e.path)
      2'd0: t = "R1";
      2'd1: t = "R3";
      2'd2: t = "R5";
      default: t = (code == 3'd0) ? "R6" : (code == 3'd2 || code == 3'd3) ? "R7" : "R8";
    endcase
    chk("R10", "valid", 64'(out_valid), 64'd1);
    chk(ptag, "path", 64'(out_path), 64'(e.path));
    if (e.path == 2'd1) chk("R3", "win", 64'(out_win), 64'(e.win));
    chk(t, "paddr", 64'(out_paddr), 64'(e.paddr));
    chk(t, "perm", 64'(out_perm), 64'(e.perm));
    chk(t, "fault", 64'(out_fault), 64'(e.fault));
    chk(t, "exc", 64'(out_exc), 64'(e.exc));
    chk("R7", "refill", 64'(out_refill), 64'(e.refill));
    chk("R7", "vppn", 64'(out_vppn), 64'(e.vppn));
    chk("R9", "badv", out_badv, exp_badv);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = 64'h0123_4567_89AB_CDEF;
    tlb_code  = 3'd2;
    @(posedge clk); #1;
    chk("R10", "idle valid", 64'(out_valid), 64'd0);
    chk("R10", "idle fault", 64'(out_fault), 64'd0);
    chk("R10", "idle refill", 64'(out_refill), 64'd0);
    chk("R9", "idle badv", out_badv, exp_badv);
  endtask

  function automatic logic [63:0] wcfg(input logic [15:0] tag, input logic [3:0] en);
    return {tag, 44'h5A5_A5A5_A5A5, en};
  endfunction

  function automatic logic [15:0] pick_tag(input logic [255:0] cfg);
    int unsigned r;
    r = $urandom_range(0, 7);
    if (r < 4) return cfg[r*64+48 +: 16];
    if (r == 4) return 16'h0000;
    if (r == 5) return 16'hFFFF;
    return 16'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] cfg;
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_plv = '0;
    direct_en = 1'b0; paging_en = 1'b0; win_cfg = '0;
    tlb_code = '0; tlb_paddr = '0; tlb_perm = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset valid", 64'(out_valid), 64'd0);
    chk("R10", "reset paddr", 64'(out_paddr), 64'd0);
    chk("R10", "reset fault", 64'(out_fault), 64'd0);
    chk("R10", "reset exc", 64'(out_exc), 64'd0);
    chk("R10", "reset badv", out_badv, 64'd0);
    @(negedge clk); rst = 1'b0;

    // windows: 0 tag 9000 level3 only, 1 tag 9000 level0 only, 2 tag A000 both, 3 tag A000 both
    cfg = {wcfg(16'hA000, 4'b1001), wcfg(16'hA000, 4'b1001),
           wcfg(16'h9000, 4'b0001), wcfg(16'h9000, 4'b1000)};

    // R1: direct mode beats a hitting window, high bits dropped
    txn(64'hA000_1234_5678_9ABC, 2'd1, 2'd0, 1'b1, 1'b0, cfg, 3'd2, '0, '0, "R1");
    txn(64'hFFFF_0000_0000_1000, 2'd2, 2'd3, 1'b1, 1'b0, cfg, 3'd7, '0, '0, "R1");
    // R2: privilege filter
    txn(64'h9000_0000_0000_4000, 2'd0, 2'd3, 1'b0, 1'b1, cfg, 3'd0, '0, '0, "R2");
    txn(64'h9000_0000_0000_4000, 2'd0, 2'd0, 1'b0, 1'b1, cfg, 3'd0, '0, '0, "R2");
    txn(64'h9000_0000_0000_4000, 2'd0, 2'd1, 1'b0, 1'b1, cfg, 3'd0, '0, '0, "R2");
    txn(64'hA000_0000_0000_4000, 2'd1, 2'd2, 1'b0, 1'b1, cfg, 3'd0, '0, '0, "R2");
    // R3: overlapping windows, lowest index wins
    txn(64'hA000_0000_0000_8000, 2'd2, 2'd3, 1'b1, 1'b1, cfg, 3'd0, '0, '0, "R3");
    // R4 / R5: non-canonical for each access type
    txn(64'h0001_0000_0000_0000, 2'd2, 2'd0, 1'b0, 1'b1, cfg, 3'd0, 48'h1, 3'd7, "R4");
    txn(64'hFFFE_FFFF_FFFF_FFFF, 2'd0, 2'd0, 1'b0, 1'b1, cfg, 3'd0, 48'h1, 3'd7, "R4");
    txn(64'h8000_0000_0000_0000, 2'd1, 2'd0, 1'b0, 1'b0, cfg, 3'd0, 48'h1, 3'd7, "R4");
    idle();
    // R6/R7/R8: every TLB code crossed with every access type on canonical addresses
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 3; a++) begin
        txn({16'hFFFF, 48'h8765_4321_E000 + 48'(c*16 + a)}, 2'(a), 2'd3, 1'b0, 1'b1, cfg,
            3'(c), 48'hBEEF_0000_1000, 3'b101, "R4");
        txn({16'h0000, 48'h0000_7654_2000 + 48'(c*16 + a)}, 2'(a), 2'd1, 1'b0, 1'b0, cfg,
            3'(c), 48'h1234_5678_9000, 3'b011, "R4");
      end
    end
    idle();
    idle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        idle();
      end else begin
        logic [63:0] va;
        if ($urandom_range(0, 15) == 0) begin
          for (int w = 0; w < 4; w++) begin
            logic [15:0] tg;
            int unsigned k;
            k  = $urandom_range(0, 3);
            tg = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h9000 : 16'($urandom);
            cfg[w*64 +: 64] = {tg, 32'($urandom), 12'($urandom), 4'($urandom)};
          end
        end
        va = {pick_tag(cfg), 16'($urandom), 32'($urandom)};
        txn(va, 2'($urandom_range(0, 2)), 2'($urandom), 1'($urandom), 1'($urandom), cfg,
            3'($urandom), {16'($urandom), 32'($urandom)}, 3'($urandom), "R4");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule